// File: doc/BRIEF.md
# Decode-Stage Conditional Branch Resolver

This block settles a branch-if-equal while the branch is still in the decode stage of a five-stage in-order pipeline. Two steps used to wait for the execute and memory stages, and both now happen in decode. The first is a bitwise XOR of the two register operands followed by an OR-reduction. The second is a dedicated adder that adds the incremented fetch address to the branch offset. The offset is sign-extended and scaled to words, which needs only wiring.

When the branch is taken, the block does two things in the same cycle. It tells the fetch stage to load the computed target as the next PC, and it asks for the fetch/decode register to be cleared. Clearing that register turns the one wrong-path instruction already fetched into a slot with all-zero control, so it writes no register and no memory. A not-taken branch changes nothing, and fetch carries on in sequence.

While the load-use stall holds the decode stage, the branch operands may still be stale. In that case the block neither redirects nor flushes, and it decides in the first cycle the hold is released. The block is purely combinational. The comparator structure and the adder structure are each chosen by a parameter.

Top module: `dec_branch_unit`

## Requirements
- R1: `tgt_addr` equals `pc_inc` plus the 16-bit `br_ofs`, sign-extended and shifted left by 2, modulo 2^ADDR_W. The two lowest bits of `tgt_addr` therefore always equal those of `pc_inc`.
- R2: Two operands count as equal only when every bit matches. A difference in any single bit position, from 0 to DATA_W-1, prevents a redirect.
- R3: `pc_sel_tgt` is 1 exactly when `is_beq` = 1, `opnd_a` equals `opnd_b` and `dec_hold` = 0. Otherwise it is 0, and with idle inputs both control outputs are 0.
- R4: `if_flush` is 1 in exactly the cycles where `pc_sel_tgt` is 1. Exactly one following instruction is discarded per taken branch.
- R5: While `dec_hold` = 1, neither `pc_sel_tgt` nor `if_flush` is raised, even when `is_beq` = 1 and the operands match.
- R6: With `is_beq` = 0, neither `pc_sel_tgt` nor `if_flush` is raised, whatever the operand values.
- R7: A branch fetched at address 40 (so `pc_inc` = 44) with offset 7 produces a target of 72. The fetch after the decision is at 72.
- R8: A negative offset moves the target backwards. Offset 0xFFFF gives `pc_inc` − 4, and offset 0x8000 gives `pc_inc` − 131072.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_inc | input | ADDR_W (32) | Address of the branch plus 4 |
| br_ofs | input | IMM_W (16) | Signed word offset from the instruction |
| opnd_a | input | DATA_W (32) | First register operand read in decode |
| opnd_b | input | DATA_W (32) | Second register operand read in decode |
| is_beq | input | 1 | Decoded instruction is a branch-if-equal |
| dec_hold | input | 1 | Load-use stall is holding the decode stage |
| pc_sel_tgt | output | 1 | Next PC takes `tgt_addr` instead of the sequential address |
| tgt_addr | output | ADDR_W (32) | Computed branch target |
| if_flush | output | 1 | Clear the fetch/decode register this cycle |

## Verification
A broken comparator cell or a dropped XOR bit would show up as a redirect with mismatched operands, or as a missed redirect. It appears on `pc_sel_tgt` and `if_flush` in the same cycle as the operands, so a walking single-bit difference across every position finds it at once. A fault in the sign extension, the shift or the carry between the adder halves changes `tgt_addr` straight away. The offsets are chosen to be positive, negative, most-negative and carry-crossing so that each of these faults is exposed. If the stall gate were lost, a redirect would appear during a held cycle, which would skip the real operands and be visible in that same cycle.

// File: rtl/bru_pkg.sv
package bru_pkg;

   // Comparator structure: balanced OR tree over the XOR vector, or one flat reduction.
   typedef enum logic [0:0] {
      CMP_TREE = 1'b0,
      CMP_FLAT = 1'b1
   } cmp_style_e;

   // Target adder structure: single carry chain, or two halves with carry select.
   typedef enum logic [0:0] {
      ADD_RIPPLE = 1'b0,
      ADD_CSEL   = 1'b1
   } add_style_e;

   // Number of tree levels needed to reduce n leaves to one.
   function automatic int unsigned tree_levels(input int unsigned n);
      int unsigned lv;
      lv = 0;
      while ((1 << lv) < n) lv++;
      return lv;
   endfunction

endpackage

// File: rtl/bru_eq_cmp.sv
module bru_eq_cmp #(
   parameter int                  DATA_W = 32,
   parameter bru_pkg::cmp_style_e STYLE  = bru_pkg::CMP_TREE
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              same
);
   localparam int LVLS   = bru_pkg::tree_levels(DATA_W);
   localparam int LEAVES = 1 << LVLS;

   initial begin
      assert (DATA_W >= 1) else $error("bru_eq_cmp: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] diff;
   assign diff = a ^ b;

   generate
      if (STYLE == bru_pkg::CMP_TREE) begin : g_tree
         logic [LEAVES-1:0] pad;
         assign pad = LEAVES'(diff);
         for (genvar l = 0; l < LVLS; l++) begin : g_lvl
            localparam int W = LEAVES >> (l + 1);
            logic [W-1:0] r;
            for (genvar k = 0; k < W; k++) begin : g_node
               if (l == 0) begin : g_leaf
                  assign r[k] = pad[2*k] | pad[2*k+1];
               end else begin : g_inner
                  assign r[k] = g_lvl[l-1].r[2*k] | g_lvl[l-1].r[2*k+1];
               end
            end
         end
         if (LVLS == 0) begin : g_single
            assign same = ~pad[0];
         end else begin : g_root
            assign same = ~g_lvl[LVLS-1].r[0];
         end
      end else begin : g_flat
         assign same = ~|diff;
      end
   endgenerate

   // R2: the reduction agrees with a full-width compare
   always_comb begin
      a_r2_eq_full_width: assert (same == (a == b))
         else $error("a_r2_eq_full_width: comparator disagrees with operand compare");
   end

endmodule

// File: rtl/bru_tgt_gen.sv
module bru_tgt_gen #(
   parameter int                  ADDR_W = 32,
   parameter int                  IMM_W  = 16,
   parameter int                  SHIFT  = 2,
   parameter bru_pkg::add_style_e STYLE  = bru_pkg::ADD_RIPPLE
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IMM_W-1:0]  ofs,
   output logic [ADDR_W-1:0] tgt
);
   localparam int LO_W = ADDR_W / 2;
   localparam int HI_W = ADDR_W - LO_W;

   initial begin
      assert (IMM_W + SHIFT <= ADDR_W) else $error("bru_tgt_gen: offset does not fit address");
      assert (ADDR_W >= 2) else $error("bru_tgt_gen: ADDR_W too small");
   end

   // Sign extension and word scaling: wiring only.
   logic [ADDR_W-1:0] sx;
   logic [ADDR_W-1:0] disp;
   assign sx   = ADDR_W'($signed(ofs));
   assign disp = sx << SHIFT;

   generate
      if (STYLE == bru_pkg::ADD_CSEL) begin : g_csel
         logic [LO_W:0]   lo_sum;
         logic [HI_W-1:0] hi_c0;
         logic [HI_W-1:0] hi_c1;
         assign lo_sum = {1'b0, base[LO_W-1:0]} + {1'b0, disp[LO_W-1:0]};
         assign hi_c0  = base[ADDR_W-1:LO_W] + disp[ADDR_W-1:LO_W];
         assign hi_c1  = hi_c0 + HI_W'(1);
         assign tgt    = {(lo_sum[LO_W] ? hi_c1 : hi_c0), lo_sum[LO_W-1:0]};
      end else begin : g_ripple
         assign tgt = base + disp;
      end

      if (SHIFT > 0) begin : g_chk_low
         // R1: scaled offset leaves the low address bits untouched
         always_comb begin
            a_r1_low_bits_kept: assert (tgt[SHIFT-1:0] == base[SHIFT-1:0])
               else $error("a_r1_low_bits_kept: target low bits altered");
         end
      end
   endgenerate

endmodule

// File: rtl/bru_flush_ctl.sv
module bru_flush_ctl (
   input  logic is_beq,
   input  logic same,
   input  logic hold,
   output logic sel_tgt,
   output logic flush
);
   logic decide;

   // A held decode stage may still carry stale operands: wait for release.
   assign decide  = is_beq & ~hold;
   assign sel_tgt = decide & same;
   assign flush   = decide & same;

   // R5: no redirect or flush while decode is held
   always_comb begin
      a_r5_quiet_in_hold: assert (!(hold && (sel_tgt || flush)))
         else $error("a_r5_quiet_in_hold: action during decode hold");
   end

   // R4: flush accompanies every redirect and nothing else
   always_comb begin
      a_r4_flush_with_redirect: assert (flush == sel_tgt)
         else $error("a_r4_flush_with_redirect: flush and redirect differ");
   end

endmodule

// File: rtl/dec_branch_unit.sv
module dec_branch_unit #(
   parameter int                  ADDR_W    = 32,
   parameter int                  DATA_W    = 32,
   parameter int                  IMM_W     = 16,
   parameter int                  SHIFT     = 2,
   parameter bru_pkg::cmp_style_e CMP_STYLE = bru_pkg::CMP_TREE,
   parameter bru_pkg::add_style_e ADD_STYLE = bru_pkg::ADD_CSEL
) (
   input  logic [ADDR_W-1:0] pc_inc,
   input  logic [IMM_W-1:0]  br_ofs,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              is_beq,
   input  logic              dec_hold,
   output logic              pc_sel_tgt,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic              if_flush
);
   initial begin
      assert (IMM_W >= 1) else $error("dec_branch_unit: IMM_W must be at least 1");
      assert (IMM_W + SHIFT <= ADDR_W) else $error("dec_branch_unit: offset wider than address");
   end

   logic ops_same;

   bru_eq_cmp #(
      .DATA_W (DATA_W),
      .STYLE  (CMP_STYLE)
   ) u_cmp (
      .a    (opnd_a),
      .b    (opnd_b),
      .same (ops_same)
   );

   bru_tgt_gen #(
      .ADDR_W (ADDR_W),
      .IMM_W  (IMM_W),
      .SHIFT  (SHIFT),
      .STYLE  (ADD_STYLE)
   ) u_tgt (
      .base (pc_inc),
      .ofs  (br_ofs),
      .tgt  (tgt_addr)
   );

   bru_flush_ctl u_ctl (
      .is_beq  (is_beq),
      .same    (ops_same),
      .hold    (dec_hold),
      .sel_tgt (pc_sel_tgt),
      .flush   (if_flush)
   );

   // R2: a redirect only ever follows matching operands
   always_comb begin
      a_r2_take_needs_match: assert (!pc_sel_tgt || (opnd_a == opnd_b))
         else $error("a_r2_take_needs_match: redirect with differing operands");
   end

   // R6: no branch, no redirect
   always_comb begin
      a_r6_idle_no_redirect: assert (is_beq || (!pc_sel_tgt && !if_flush))
         else $error("a_r6_idle_no_redirect: redirect without branch");
   end

endmodule

// File: tb/dec_branch_unit_tb.sv
module dec_branch_unit_tb;
   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] pc_inc = '0;
   logic [15:0]   br_ofs = '0;
   logic [DW-1:0] opnd_a = '0;
   logic [DW-1:0] opnd_b = '0;
   logic          is_beq = 1'b0;
   logic          dec_hold = 1'b0;
   logic          pc_sel_tgt;
   logic [AW-1:0] tgt_addr;
   logic          if_flush;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   // expected item: {sel, flush, target}
   logic [AW+1:0] exp_q[$];
   string         tag_q[$];

   always #10 clk = ~clk;

   dec_branch_unit u_dut (
      .pc_inc     (pc_inc),
      .br_ofs     (br_ofs),
      .opnd_a     (opnd_a),
      .opnd_b     (opnd_b),
      .is_beq     (is_beq),
      .dec_hold   (dec_hold),
      .pc_sel_tgt (pc_sel_tgt),
      .tgt_addr   (tgt_addr),
      .if_flush   (if_flush)
   );

   // Reference: taken only when branch, equal and not held; target by signed arithmetic.
   task automatic drive(input logic [AW-1:0] pc, input logic [15:0] ofs,
                        input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic br, input logic hold, input string tag);
      logic          tk;
      logic [AW-1:0] tg;
      @(posedge clk);
      #2;
      pc_inc = pc; br_ofs = ofs; opnd_a = a; opnd_b = b; is_beq = br; dec_hold = hold;
      tk = br && !hold && (a == b);
      tg = pc + AW'($signed(ofs) * 4);
      exp_q.push_back({tk, tk, tg});
      tag_q.push_back(tag);
   endtask

   // Monitor: one expected item per cycle, sampled at the falling edge.
   always @(negedge clk) begin
      if (!rst && exp_q.size() > 0) begin
         logic [AW+1:0] e;
         logic [AW+1:0] got;
         string t;
         e   = exp_q.pop_front();
         t   = tag_q.pop_front();
         got = {pc_sel_tgt, if_flush, tgt_addr};
         checks++;
         if (got !== e) begin
            errors++;
            $display("FAIL %s: sel/flush/target got %b/%b/%h expected %b/%b/%h",
                     t, got[AW+1], got[AW], got[AW-1:0], e[AW+1], e[AW], e[AW-1:0]);
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // R3: idle inputs after reset
      drive(32'd0, 16'd0, 32'd0, 32'd0, 1'b0, 1'b0, "R3 idle");
      // R7: branch at 40, offset 7 lands at 72
      drive(32'd44, 16'd7, 32'h1234_5678, 32'h1234_5678, 1'b1, 1'b0, "R7 example");
      // R3: taken with equal operands
      drive(32'h0000_1000, 16'd100, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, 1'b0, "R3 taken");
      // R3/R4: not taken on unequal operands
      drive(32'h0000_1000, 16'd100, 32'hDEAD_BEEF, 32'hDEAD_BEEE, 1'b1, 1'b0, "R4 not taken");
      // R5: held decode with matching operands
      drive(32'd44, 16'd7, 32'd5, 32'd5, 1'b1, 1'b1, "R5 hold");
      // R5: released the next cycle, decision made then
      drive(32'd44, 16'd7, 32'd5, 32'd5, 1'b1, 1'b0, "R5 release");
      // R6: equal operands but no branch
      drive(32'h0040_0000, 16'd3, 32'd9, 32'd9, 1'b0, 1'b0, "R6 no branch");
      // R6: no branch while held
      drive(32'h0040_0000, 16'd3, 32'd0, 32'd0, 1'b0, 1'b1, "R6 held idle");
      // R8: negative offsets
      drive(32'h0000_2000, 16'hFFFF, 32'd0, 32'd0, 1'b1, 1'b0, "R8 minus one");
      drive(32'h0010_0000, 16'h8000, 32'd1, 32'd1, 1'b1, 1'b0, "R8 most negative");
      // R1: carry across the adder halves and address wrap
      drive(32'h0000_FFFC, 16'h0001, 32'd0, 32'd1, 1'b1, 1'b0, "R1 half carry");
      drive(32'hFFFF_FFFC, 16'h0002, 32'd0, 32'd0, 1'b1, 1'b0, "R1 wrap");
      drive(32'h8000_0002, 16'h7FFF, 32'd7, 32'd7, 1'b1, 1'b0, "R1 max offset");
      // R2: walking single-bit difference across every position
      for (int i = 0; i < DW; i++) begin
         drive(32'h0000_0100, 16'd4, 32'hA5A5_5A5A, 32'hA5A5_5A5A ^ (32'd1 << i),
               1'b1, 1'b0, "R2 bit diff");
      end
      // R2: all-ones versus all-ones is a match
      drive(32'h0000_0100, 16'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R2 ones");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule